// File: doc/BRIEF.md
# Programmable Raster Timing Controller

This block generates the timing for a character-mapped display. It runs on the character clock. A host programs it through two byte-wide write ports. A write to the select port picks one of sixteen configuration registers, and the following write to the data port loads that register. From these settings the block counts character columns, scanlines within a character row, and character rows. It then drives horizontal sync, vertical sync, display enable, a linear character memory address, the scanline-within-row address and a cursor strobe.

Each frame is made of a programmable number of character rows, all of the same programmable height. After the last row, a separate count of extra scanlines fine-tunes the frame length. The memory address begins at a programmable start address and advances by the visible width once per row. A status byte exposes blanking and vertical-sync state, so that software can poll it.

Top module: `raster_timer`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata[3:0]` as the register index and ignores the upper nibble. A write with `bus_sel`=1 loads the register at that index. Register numbers: 0 line total, 1 visible columns, 2 hsync start, 3 hsync width, 4 row total, 5 extra scanlines, 6 visible rows, 7 vsync row, 8 interlace mode, 9 last scanline, 10 cursor top, 11 cursor bottom, 12/13 start address high/low, 14/15 cursor address high/low.
- R2: Each register keeps only its own width, and writes drop the bits above it. Widths: 0–2 are 8 bits, 3 is 4 bits, 4/6/7 are 7 bits, 5/9/11 are 5 bits, 8 is 2 bits, and 12/14 are 6 bits. Register 10 holds the cursor top in bits 4:0 and a 2-bit mode in bits 6:5. Registers 13/15 are 8 bits. `ilace_mode` shows register 8 and `cur_mode` shows the register 10 mode field.
- R3: A line lasts (register 0 + 1) character clocks, and columns run from 0 upward.
- R4: A frame lasts (register 4 + 1) × (register 9 + 1) + register 5 scanlines.
- R5: `de` is high when the column is below register 1, the row is below register 6, and the line is not an extra (adjust) scanline.
- R6: `hsync` is high in columns c where register 2 ≤ c < register 2 + register 3.
- R7: `vsync` rises at column 0 of scanline 0 of the row given by register 7 and stays high for exactly 16 scanlines.
- R8: `ma` = start + row × register 1 + column, modulo 2^14. The start address is taken up at each frame boundary.
- R9: `ra` gives the scanline within the current row. During the extra scanlines it counts 0 up to register 5 − 1.
- R10: `cursor` is high when `de` is high, `ma` equals the cursor address, and cursor top ≤ `ra` ≤ cursor bottom.
- R11: `status` bit 0 is 1 while `de` is low, bit 3 is 1 while `vsync` is high, and all other bits read 0.
- R12: After reset all registers and counters are zero. `de`, `hsync`, `vsync`, `cursor`, `ma` and `ra` are 0, and `status` reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the host bus |
| bus_sel | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| ma | output | 14 | Character memory address |
| ra | output | 5 | Scanline within row |
| cursor | output | 1 | Cursor strobe |
| status | output | 8 | Polling status byte |
| ilace_mode | output | 2 | Stored interlace mode field |
| cur_mode | output | 2 | Stored cursor mode field |

## Verification
The bound checker watches four properties on every cycle. The column wraps to zero after the line total. Within a line the address steps by one and the row address holds. Vertical sync only starts at the first column of a row's first scanline. The cursor never lasts two adjacent characters of one line. Only the bench's scenarios can show the things that depend on a whole programmed frame: the 26-line frame length with two extra scanlines, and its shortening when the adjust count is cleared. They also show the 16-line vertical sync that crosses rows, the address wrap past 2^14, the cursor window, and the dropping of over-wide register bits.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int AW = 14,
  parameter int VS_LINES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_sel,
  input  logic [7:0]    bus_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [AW-1:0] ma,
  output logic [4:0]    ra,
  output logic          cursor,
  output logic [7:0]    status,
  output logic [1:0]    ilace_mode,
  output logic [1:0]    cur_mode
);

  localparam int HI = AW - 8;
  localparam int VW = $clog2(VS_LINES + 1);

  logic [3:0]    idx;
  logic [7:0]    h_tot, h_disp, hs_pos;
  logic [3:0]    hs_wid;
  logic [6:0]    v_tot, v_disp, vs_row;
  logic [4:0]    v_adj, max_sl, cur_top, cur_bot;
  logic [AW-1:0] start_a, cur_a;

  logic [7:0]    hcnt;
  logic [6:0]    row;
  logic [4:0]    scan;
  logic          in_adj;
  logic [AW-1:0] row_base;
  logic [VW-1:0] vs_left;

  logic [6:0]    n_row;
  logic [4:0]    n_scan;
  logic          n_adj;
  logic [AW-1:0] n_base;
  logic          line_end, vs_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; h_tot <= '0; h_disp <= '0; hs_pos <= '0; hs_wid <= '0;
      v_tot <= '0; v_adj <= '0; v_disp <= '0; vs_row <= '0; ilace_mode <= '0;
      max_sl <= '0; cur_top <= '0; cur_mode <= '0; cur_bot <= '0;
      start_a <= '0; cur_a <= '0;
    end else if (bus_wr) begin
      if (!bus_sel) idx <= bus_wdata[3:0];
      else begin
        case (idx)
          4'd0:  h_tot  <= bus_wdata;
          4'd1:  h_disp <= bus_wdata;
          4'd2:  hs_pos <= bus_wdata;
          4'd3:  hs_wid <= bus_wdata[3:0];
          4'd4:  v_tot  <= bus_wdata[6:0];
          4'd5:  v_adj  <= bus_wdata[4:0];
          4'd6:  v_disp <= bus_wdata[6:0];
          4'd7:  vs_row <= bus_wdata[6:0];
          4'd8:  ilace_mode <= bus_wdata[1:0];
          4'd9:  max_sl <= bus_wdata[4:0];
          4'd10: begin cur_top <= bus_wdata[4:0]; cur_mode <= bus_wdata[6:5]; end
          4'd11: cur_bot <= bus_wdata[4:0];
          4'd12: start_a[AW-1:8] <= bus_wdata[HI-1:0];
          4'd13: start_a[7:0] <= bus_wdata;
          4'd14: cur_a[AW-1:8] <= bus_wdata[HI-1:0];
          default: cur_a[7:0] <= bus_wdata;
        endcase
      end
    end
  end

  assign line_end = hcnt >= h_tot;

  always_comb begin
    n_row  = row;
    n_scan = scan;
    n_adj  = in_adj;
    n_base = row_base;
    if (in_adj) begin
      if ({1'b0, scan} + 6'd1 >= {1'b0, v_adj}) begin
        n_adj  = 1'b0;
        n_row  = '0;
        n_scan = '0;
        n_base = start_a;
      end else n_scan = scan + 5'd1;
    end else if (scan >= max_sl) begin
      n_scan = '0;
      if (row >= v_tot) begin
        if (v_adj == '0) begin
          n_row  = '0;
          n_base = start_a;
        end else n_adj = 1'b1;
      end else begin
        n_row  = row + 7'd1;
        n_base = row_base + AW'(h_disp);
      end
    end else n_scan = scan + 5'd1;
  end

  assign vs_hit = !n_adj && n_scan == '0 && n_row == vs_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0; row <= '0; scan <= '0; in_adj <= 1'b0;
      row_base <= '0; vs_left <= '0;
    end else begin
      hcnt <= line_end ? 8'd0 : hcnt + 8'd1;
      if (line_end) begin
        row      <= n_row;
        scan     <= n_scan;
        in_adj   <= n_adj;
        row_base <= n_base;
        if (vs_hit) vs_left <= VW'(VS_LINES);
        else if (vs_left != '0) vs_left <= vs_left - 1'b1;
      end
    end
  end

  assign vsync  = vs_left != '0;
  assign de     = !in_adj && hcnt < h_disp && row < v_disp;
  assign hsync  = {1'b0, hcnt} >= {1'b0, hs_pos} &&
                  {1'b0, hcnt} < {1'b0, hs_pos} + {5'b0, hs_wid};
  assign ma     = row_base + AW'(hcnt);
  assign ra     = scan;
  assign cursor = de && ma == cur_a && scan >= cur_top && scan <= cur_bot;
  assign status = {4'b0, vsync, 2'b0, ~de};

endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [7:0]    hcnt,
  input logic [7:0]    h_tot,
  input logic [4:0]    scan,
  input logic [AW-1:0] ma,
  input logic [4:0]    ra,
  input logic          vsync,
  input logic          cursor
);

  assert_line_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt >= h_tot) |=> (hcnt == 8'd0));

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt < h_tot) |=> (ma == $past(ma) + AW'(1)));

  assert_ra_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt < h_tot) |=> $stable(ra));

  assert_vsync_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (hcnt == 8'd0 && scan == 5'd0));

  assert_cursor_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cursor && hcnt < h_tot && !bus_wr) |=> !cursor);

endmodule

bind raster_timer raster_timer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .hcnt(hcnt), .h_tot(h_tot),
  .scan(scan), .ma(ma), .ra(ra), .vsync(vsync), .cursor(cursor)
);

// File: tb/sim_raster_timer.sv
module sim_raster_timer;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 10;
  localparam int FRAME = 260;
  localparam int NV = 19;

  // {line, col, de, hsync, vsync, ma, ra, cursor}
  localparam logic [38:0] VEC [NV] = '{
    {8'd0,  8'd0, 1'b1, 1'b0, 1'b0, 14'h3FFE, 5'd0, 1'b0},
    {8'd0,  8'd5, 1'b1, 1'b0, 1'b0, 14'h0003, 5'd0, 1'b0},
    {8'd0,  8'd6, 1'b0, 1'b0, 1'b0, 14'h0000, 5'd0, 1'b0},
    {8'd0,  8'd7, 1'b0, 1'b1, 1'b0, 14'h0000, 5'd0, 1'b0},
    {8'd0,  8'd8, 1'b0, 1'b1, 1'b0, 14'h0000, 5'd0, 1'b0},
    {8'd0,  8'd9, 1'b0, 1'b0, 1'b0, 14'h0000, 5'd0, 1'b0},
    {8'd3,  8'd2, 1'b1, 1'b0, 1'b0, 14'h0000, 5'd3, 1'b0},
    {8'd5,  8'd1, 1'b1, 1'b0, 1'b0, 14'h0005, 5'd1, 1'b1},
    {8'd6,  8'd1, 1'b1, 1'b0, 1'b0, 14'h0005, 5'd2, 1'b1},
    {8'd4,  8'd1, 1'b1, 1'b0, 1'b0, 14'h0005, 5'd0, 1'b0},
    {8'd7,  8'd1, 1'b1, 1'b0, 1'b0, 14'h0005, 5'd3, 1'b0},
    {8'd5,  8'd2, 1'b1, 1'b0, 1'b0, 14'h0006, 5'd1, 1'b0},
    {8'd8,  8'd0, 1'b1, 1'b0, 1'b1, 14'h000A, 5'd0, 1'b0},
    {8'd11, 8'd5, 1'b1, 1'b0, 1'b1, 14'h000F, 5'd3, 1'b0},
    {8'd12, 8'd0, 1'b0, 1'b0, 1'b1, 14'h0000, 5'd0, 1'b0},
    {8'd23, 8'd3, 1'b0, 1'b0, 1'b1, 14'h0000, 5'd3, 1'b0},
    {8'd24, 8'd0, 1'b0, 1'b0, 1'b0, 14'h0000, 5'd0, 1'b0},
    {8'd25, 8'd9, 1'b0, 1'b0, 1'b0, 14'h0000, 5'd1, 1'b0},
    {8'd25, 8'd7, 1'b0, 1'b1, 1'b0, 14'h0000, 5'd1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic hsync, vsync, de, cursor;
  logic [13:0] ma;
  logic [4:0] ra;
  logic [7:0] status;
  logic [1:0] ilace_mode, cur_mode;
  int cyc = 0, n_chk = 0, n_fail = 0;

  raster_timer u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc == 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ix, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = ix;
    @(negedge clk); bus_sel = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic vs_rise(output int at);
    @(negedge clk);
    while (vsync) @(negedge clk);
    while (!vsync) @(negedge clk);
    at = cyc;
  endtask

  initial begin
    int base, t0, t1, hcount;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 de", de, 0); chk("R12 hsync", hsync, 0); chk("R12 vsync", vsync, 0);
    chk("R12 ma", ma, 0); chk("R12 ra", ra, 0); chk("R12 cursor", cursor, 0);
    chk("R12 status", status, 8'h01); chk("R12 ilace", ilace_mode, 0);
    rst_n = 1'b1;

    wr(8'd0, 8'd9);  wr(8'd1, 8'd6);  wr(8'd2, 8'd7);  wr(8'd3, 8'd2);
    wr(8'd4, 8'd5);  wr(8'd5, 8'd2);  wr(8'd6, 8'd3);  wr(8'd7, 8'd2);
    wr(8'd9, 8'd3);  wr(8'd10, 8'd1); wr(8'd11, 8'd2); wr(8'd12, 8'h3F);
    wr(8'd13, 8'hFE); wr(8'd14, 8'h00); wr(8'd15, 8'h05);

    vs_rise(base);
    vs_rise(base);
    for (int i = 0; i < NV; i++) begin
      int ln, cl, tgt;
      ln = int'(VEC[i][38:31]); cl = int'(VEC[i][30:23]);
      tgt = base + (ln * LINE + cl - 8 * LINE + FRAME) % FRAME;
      while (tgt < cyc) tgt += FRAME;
      while (cyc != tgt) @(negedge clk);
      chk("R5 de", de, VEC[i][22]);
      chk("R6 hsync", hsync, VEC[i][21]);
      chk("R7 vsync", vsync, VEC[i][20]);
      if (VEC[i][22]) chk("R8 ma", ma, VEC[i][19:6]);
      chk("R9 ra", ra, VEC[i][5:1]);
      chk("R10 cursor", cursor, VEC[i][0]);
      chk("R11 status bit3", status[3], VEC[i][20]);
      chk("R11 status bit0", status[0], !VEC[i][22]);
    end

    // R4 frame length with adjust lines, R3 line length
    vs_rise(t0); vs_rise(t1);
    chk("R4 frame cycles", t1 - t0, FRAME);
    while (hsync) @(negedge clk);
    while (!hsync) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (hsync) @(negedge clk);
    while (!hsync) @(negedge clk);
    chk("R3 line cycles", cyc - t0, LINE);

    // R4 without adjust lines
    vs_rise(t0);
    wr(8'd5, 8'd0);
    vs_rise(t0); vs_rise(t1);
    chk("R4 frame no adjust", t1 - t0, 240);

    // R1 index upper nibble ignored, R2 masks
    wr(8'h18, 8'h01);
    chk("R1 index low nibble", ilace_mode, 2'd1);
    wr(8'd8, 8'hFF);
    chk("R2 interlace mask", ilace_mode, 2'd3);
    wr(8'd10, 8'hE1);
    chk("R2 cursor mode field", cur_mode, 2'd3);
    wr(8'd3, 8'hF3);
    while (!(hsync === 1'b0 && de === 1'b1)) @(negedge clk);
    hcount = 0;
    for (int k = 0; k < LINE; k++) begin
      if (hsync) hcount++;
      @(negedge clk);
    end
    chk("R2 hsync width mask", hcount, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule